// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block carries out 32-bit integer multiplication and division, signed or unsigned, over a number of clock cycles instead of in one wide combinational step. A single shift-and-add/subtract datapath with one adder serves both operations. That adder does one partial-product add or one trial subtraction in each cycle. The caller presents two operands and an operation code together with a one-cycle start pulse. It then reads two result registers, the high word and the low word, once the unit reports completion.

For a multiplication, the two result registers hold the two halves of the 64-bit product. For a division, the high word holds the remainder and the low word holds the quotient. Signed operations run on operand magnitudes and fix the signs at the end. No trap is raised for a zero divisor or for a quotient that does not fit: each of these cases returns a fixed, documented value.

Top module: `seq_muldiv`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and both `hiWord` and `loWord` are 0.
- R2: The unit accepts `startIn` at a rising clock edge where `busy` is 0. From that edge, `busy` is 1 for exactly 32 cycles and `done` is 0. At the end of the 32nd cycle, `busy` drops, `done` rises and the new results appear in `hiWord`/`loWord`.
- R3: A `startIn` pulse while `busy` is 1 has no effect. The running operation keeps its operands and its 32-cycle length.
- R4: With `opSel` = 2'b01 (unsigned multiply), `{hiWord, loWord}` is the 64-bit unsigned product of `srcA` and `srcB`.
- R5: With `opSel` = 2'b00 (signed multiply), `{hiWord, loWord}` is the 64-bit two's-complement product of `srcA` and `srcB`.
- R6: With `opSel` = 2'b11 (unsigned divide), `loWord` is `srcA / srcB` and `hiWord` is `srcA % srcB`.
- R7: With `opSel` = 2'b10 (signed divide), `loWord` is the quotient truncated toward zero. It is negated when the operand signs differ. `hiWord` is the remainder, which carries the sign of the dividend.
- R8: A zero divisor returns the dividend in `hiWord`. `loWord` is all ones, except for a signed divide with a negative dividend, where `loWord` is 1.
- R9: `hiWord` and `loWord` keep their previous values while an operation runs and after `done`, until the next operation finishes.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF returns quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | One-cycle request to begin an operation |
| opSel | input | 2 | Bit 1: divide (1) / multiply (0); bit 0: unsigned (1) / signed (0) |
| srcA | input | 32 | Multiplicand or dividend |
| srcB | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation iterates |
| done | output | 1 | High once results are valid, until the next accepted start |
| hiWord | output | 32 | Product high half or remainder |
| loWord | output | 32 | Product low half or quotient |

## Verification
A new start request and an operation that is still iterating can meet in the same cycle. The bench provokes this by asserting `startIn` in the middle of a run, with different operands and a different operation code. It then judges the outcome in two ways. The busy window must still count exactly 32 cycles. The results must match the first request, never the intruding one. A second overlap occurs when a start lands on the first cycle after completion. The bench checks that the old results stay visible throughout the new run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Operation code fields
  localparam int OP_DIV_BIT  = 1;
  localparam int OP_UNS_BIT  = 0;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, start an operation
    logic step;    // one iteration
    logic finish;  // last iteration: write results
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  output logic      busy,
  output logic      done,
  output mdStrobe_t strb
);

  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    strb.load   = startIn && !busy;
    strb.step   = busy;
    strb.finish = busy && (stepCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else if (strb.load) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      stepCnt <= '0;
    end else if (strb.finish) begin
      busy    <= 1'b0;
      done    <= 1'b1;
      stepCnt <= '0;
    end else if (busy) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // R2
  busy_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepCnt != LAST) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

  // R3
  restart_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startIn && stepCnt != LAST) |=> (stepCnt != '0));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.finish}));

endmodule

// File: rtl/muldiv_path.sv
module muldiv_path
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strb,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] hiReg,
  output logic [WIDTH-1:0] loReg
);

  localparam int AW = WIDTH + 2;

  logic             modeDiv, negHi, negLo;
  logic [WIDTH-1:0] workHi, workLo, divisor;

  // operand magnitudes at load
  logic             isSigned, signA, signB;
  logic [WIDTH-1:0] magA, magB;

  always_comb begin
    isSigned = !opSel[OP_UNS_BIT];
    signA    = isSigned && srcA[WIDTH-1];
    signB    = isSigned && srcB[WIDTH-1];
    magA     = signA ? (~srcA + 1'b1) : srcA;
    magB     = signB ? (~srcB + 1'b1) : srcB;
  end

  // one shared adder: add for multiply, subtract for divide
  logic [AW-1:0]    addA, addB, addSum;
  logic [WIDTH:0]   partial;
  logic             trialNeg;
  logic [WIDTH-1:0] nextHi, nextLo;

  always_comb begin
    addA = modeDiv ? {1'b0, workHi, workLo[WIDTH-1]} : {2'b00, workHi};
    addB = {2'b00, divisor};
    addSum = addA + (modeDiv ? ~addB : addB) + {{(AW-1){1'b0}}, modeDiv};
    trialNeg = addSum[AW-1];
    partial  = '0;
    if (modeDiv) begin
      nextHi = trialNeg ? addA[WIDTH-1:0] : addSum[WIDTH-1:0];
      nextLo = {workLo[WIDTH-2:0], ~trialNeg};
    end else begin
      partial = workLo[0] ? addSum[WIDTH:0] : {1'b0, workHi};
      nextHi  = partial[WIDTH:1];
      nextLo  = {partial[0], workLo[WIDTH-1:1]};
    end
  end

  // sign fix-up of the final values
  logic [2*WIDTH-1:0] prodMag, prodFix;
  logic [WIDTH-1:0]   fixHi, fixLo;

  always_comb begin
    prodMag = {nextHi, nextLo};
    prodFix = negLo ? (~prodMag + 1'b1) : prodMag;
    if (modeDiv) begin
      fixHi = negHi ? (~nextHi + 1'b1) : nextHi;
      fixLo = negLo ? (~nextLo + 1'b1) : nextLo;
    end else begin
      fixHi = prodFix[2*WIDTH-1:WIDTH];
      fixLo = prodFix[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeDiv <= 1'b0;
      negHi   <= 1'b0;
      negLo   <= 1'b0;
      workHi  <= '0;
      workLo  <= '0;
      divisor <= '0;
      hiReg   <= '0;
      loReg   <= '0;
    end else if (strb.load) begin
      modeDiv <= opSel[OP_DIV_BIT];
      negLo   <= signA ^ signB;
      negHi   <= opSel[OP_DIV_BIT] ? signA : (signA ^ signB);
      workHi  <= '0;
      workLo  <= magA;
      divisor <= magB;
    end else if (strb.step) begin
      workHi <= nextHi;
      workLo <= nextLo;
      if (strb.finish) begin
        hiReg <= fixHi;
        loReg <= fixLo;
      end
    end
  end

  // R6: partial remainder stays below a nonzero divisor while iterating
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && modeDiv && divisor != '0) |-> (workHi < divisor));

  // R8: a zero divisor never yields a zero quotient bit
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && modeDiv && divisor == '0) |-> !trialNeg);

endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiWord,
  output logic [WIDTH-1:0] loWord
);

  mdStrobe_t strb;

  muldiv_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .busy    (busy),
    .done    (done),
    .strb    (strb)
  );

  muldiv_path #(.WIDTH(WIDTH)) uPath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .opSel (opSel),
    .srcA  (srcA),
    .srcB  (srcB),
    .hiReg (hiWord),
    .loReg (loWord)
  );

  // R2
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startIn) |=> (done && $stable(hiWord) && $stable(loWord)));

  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> ($stable(hiWord) && $stable(loWord)));

endmodule

// File: tb/seq_muldiv_test.sv
module seq_muldiv_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] srcA = '0, srcB = '0;
  logic        busy, done;
  logic [31:0] hiWord, loWord;

  int nTests = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  seq_muldiv uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .hiWord(hiWord), .loWord(loWord)
  );

  // {opSel, srcA, srcB}
  localparam int NV = 14;
  localparam logic [65:0] VECS [NV] = '{
    {2'b01, 32'd7,         32'd6},
    {2'b01, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {2'b01, 32'h12345678,  32'h9ABCDEF0},
    {2'b00, 32'hFFFFFFFD,  32'd5},
    {2'b00, 32'h80000000,  32'h80000000},
    {2'b00, 32'hFFFFFFF9,  32'hFFFFFFFA},
    {2'b11, 32'd100,       32'd7},
    {2'b11, 32'hFFFFFFFF,  32'd1},
    {2'b11, 32'd3,         32'd9},
    {2'b10, 32'hFFFFFFF9,  32'd2},
    {2'b10, 32'd7,         32'hFFFFFFFE},
    {2'b10, 32'hFFFFFF9C,  32'hFFFFFFF9},
    {2'b11, 32'hDEADBEEF,  32'd0},
    {2'b10, 32'h80000000,  32'hFFFFFFFF}
  };

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    logic signed [63:0] sa, sb, sq, sr;
    logic [31:0] q;
    sa = $signed({{32{a[31]}}, a});
    sb = $signed({{32{b[31]}}, b});
    case (op)
      2'b01: model = {32'b0, a} * {32'b0, b};
      2'b00: model = sa * sb;
      2'b11: model = (b == 0) ? {a, 32'hFFFFFFFF} : {a % b, a / b};
      default: begin
        if (b == 0) begin
          q = a[31] ? 32'd1 : 32'hFFFFFFFF;
          model = {a, q};
        end else begin
          sq = sa / sb;
          sr = sa % sb;
          model = {sr[31:0], sq[31:0]};
        end
      end
    endcase
  endfunction

  function automatic string tagOf(input logic [1:0] op, input logic [31:0] a,
                                  input logic [31:0] b);
    if (op[1] && b == 0) return "R8";
    if (op == 2'b10 && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R10";
    case (op)
      2'b01: return "R4";
      2'b00: return "R5";
      2'b11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue an operation; optionally inject a foreign start mid-run (R3).
  task automatic runOp(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit intrude);
    logic [63:0] prev;
    int cyc;
    prev = {hiWord, loWord};
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      if (cyc == 1) check("R9 hold during run", {hiWord, loWord}, prev);
      if (intrude && cyc == 10) begin
        opSel = ~op; srcA = 32'h55555555; srcB = 32'h3; startIn = 1'b1;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
    end
    startIn = 1'b0;
    check("R2 busy cycles", 64'(cyc), 64'd32);
    check("R2 done after run", {63'b0, done}, 64'd1);
    check({tagOf(op, a, b), " result"}, {hiWord, loWord}, model(op, a, b));
  endtask

  initial begin
    #2_000_000;
    nTests++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {62'b0, busy, done}, 64'd0);
    check("R1 reset regs", {hiWord, loWord}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {62'b0, busy, done, hiWord, loWord} , 64'd0);

    for (int i = 0; i < NV; i++)
      runOp(VECS[i][65:64], VECS[i][63:32], VECS[i][31:0], 1'b0);

    // R3: start while busy is ignored
    runOp(2'b11, 32'd1000, 32'd33, 1'b1);
    runOp(2'b00, 32'hFFFFFFFF, 32'd12345, 1'b1);

    // R9: results hold while idle and done
    repeat (5) @(negedge clk);
    check("R9 hold idle", {hiWord, loWord}, model(2'b00, 32'hFFFFFFFF, 32'd12345));

    // R8: signed divide by zero with negative dividend
    runOp(2'b10, 32'hFFFFFFF0, 32'd0, 1'b0);
    // R8: signed divide by zero with positive dividend
    runOp(2'b10, 32'd7, 32'd0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule